// File: doc/BRIEF.md
# Set/Clear General-Purpose I/O Port

This block is a general-purpose I/O port of up to 32 pins, controlled through a small memory-mapped register interface made of valid, write, address and data signals. Software never changes an output level or a driver enable by writing a whole data word. Each change goes through one of four action registers instead. A one written to a bit position acts on that pin and a zero leaves it alone. Two threads of software can therefore each toggle their own pins without a read-modify-write sequence and without locking.

The port drives a level and an output-enable for each pin to the pad ring. It takes the pad levels back in through a two-flop synchronizer, and one read-only register returns them. Pin n always maps to data bit n of a 32-bit little-endian word. The action registers read back as zero. Addresses that are not decoded are ignored on write and read back as zero.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is held and after its release, every pin_out bit is 0, every pin_oe bit is 0 and rsp_valid is 0.
- R2: A write to offset 0x00 sets pin_out[n] to 1 for every n whose data bit n is 1. Every other pin keeps its level.
- R3: A write to offset 0x10 sets pin_out[n] to 0 for every n whose data bit n is 1. Every other pin keeps its level.
- R4: A write to offset 0x20 sets pin_oe[n] to 1 for every n whose data bit n is 1. Every other enable is unchanged.
- R5: A write to offset 0x30 sets pin_oe[n] to 0, releasing the pin, for every n whose data bit n is 1. Every other enable is unchanged.
- R6: A read of offset 0x40 returns pin_in[n] in bit n. The level returned is the one pin_in had at the clock edge two edges before the edge that accepted the read. Bits at and above NPIN read as 0.
- R7: A read of offsets 0x00, 0x10, 0x20 or 0x30, or of any offset that is not decoded, returns 0.
- R8: A write to any offset other than 0x00, 0x10, 0x20 and 0x30 changes neither pin_out nor pin_oe.
- R9: A write changes the outputs at the clock edge that accepts it. rsp_valid is 1 for exactly the cycle after each accepted read, and is never 1 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW (8) | Byte offset of the register |
| req_wdata | input | 32 | Write data, bit n acts on pin n |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NPIN (32) | Asynchronous pad levels |
| pin_out | output | NPIN (32) | Output level to the pad |
| pin_oe | output | NPIN (32) | Output driver enable to the pad |

## Verification
The assertions assume that a request is held stable for the whole cycle before the edge that samples it. They also assume that pin_in changes only between edges, so the property for the synchronized read can compare against a delayed copy of pin_in. The bench drives every request and every pad level on the falling edge and samples on the following falling edge. Its pad model loops the driven levels back through pin_in only through registered outputs, so both assumptions hold.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
   localparam int unsigned WORD_W = 32;
   localparam logic [7:0] OFS_LVL_SET = 8'h00;
   localparam logic [7:0] OFS_LVL_CLR = 8'h10;
   localparam logic [7:0] OFS_DRV_SET = 8'h20;
   localparam logic [7:0] OFS_DRV_CLR = 8'h30;
   localparam logic [7:0] OFS_PINS    = 8'h40;

   typedef struct packed {
      logic lvl_set;
      logic lvl_clr;
      logic drv_set;
      logic drv_clr;
      logic pins_rd;
   } gsc_strobe_t;
endpackage

// File: rtl/gsc_decode.sv
module gsc_decode
   import gsc_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          valid,
   input  logic          write,
   input  logic [AW-1:0] addr,
   output gsc_strobe_t   strb
);
   localparam logic [AW-1:0] A_LS = AW'(OFS_LVL_SET);
   localparam logic [AW-1:0] A_LC = AW'(OFS_LVL_CLR);
   localparam logic [AW-1:0] A_DS = AW'(OFS_DRV_SET);
   localparam logic [AW-1:0] A_DC = AW'(OFS_DRV_CLR);
   localparam logic [AW-1:0] A_PR = AW'(OFS_PINS);

   logic wr, rd;
   always_comb begin
      wr = valid & write;
      rd = valid & ~write;
      strb.lvl_set = wr & (addr == A_LS);
      strb.lvl_clr = wr & (addr == A_LC);
      strb.drv_set = wr & (addr == A_DS);
      strb.drv_clr = wr & (addr == A_DC);
      strb.pins_rd = rd & (addr == A_PR);
   end
endmodule

// File: rtl/gsc_sync.sv
module gsc_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gsc_pin_cell.sv
module gsc_pin_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_set,
   input  logic lvl_clr,
   input  logic drv_set,
   input  logic drv_clr,
   output logic lvl,
   output logic drv
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl <= 1'b0;
      else if (lvl_set) lvl <= 1'b1;
      else if (lvl_clr) lvl <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       drv <= 1'b0;
      else if (drv_set) drv <= 1'b1;
      else if (drv_clr) drv <= 1'b0;
   end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gsc_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned AW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe
);
   localparam int unsigned PAD_W = WORD_W - NPIN;

   if (NPIN < 1 || NPIN > WORD_W) begin : g_bad_npin
      $error("gpio_setclr_port: NPIN must lie in 1..32");
   end
   if (AW < 7) begin : g_bad_aw
      $error("gpio_setclr_port: AW must reach offset 0x40");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_setclr_port: at least two synchronizer stages");
   end

   gsc_strobe_t     strb;
   logic [NPIN-1:0] pins_sync;

   gsc_decode #(.AW(AW)) u_dec (
      .valid (req_valid),
      .write (req_write),
      .addr  (req_addr),
      .strb  (strb)
   );

   gsc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_sync)
   );

   for (genvar n = 0; n < NPIN; n++) begin : g_pin
      gsc_pin_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_set (strb.lvl_set & req_wdata[n]),
         .lvl_clr (strb.lvl_clr & req_wdata[n]),
         .drv_set (strb.drv_set & req_wdata[n]),
         .drv_clr (strb.drv_clr & req_wdata[n]),
         .lvl     (pin_out[n]),
         .drv     (pin_oe[n])
      );
   end

   logic [WORD_W-1:0] pins_word;
   if (PAD_W == 0) begin : g_full
      assign pins_word = pins_sync;
   end else begin : g_part
      assign pins_word = {{PAD_W{1'b0}}, pins_sync};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid & ~req_write;
         rsp_rdata <= strb.pins_rd ? pins_word : '0;
      end
   end
endmodule

// File: rtl/gsc_port_chk.sv
module gsc_port_chk #(
   parameter int unsigned NPIN = 32,
   parameter int unsigned AW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_write,
   input logic [AW-1:0]   req_addr,
   input logic [31:0]     req_wdata,
   input logic            rsp_valid,
   input logic [31:0]     rsp_rdata,
   input logic [NPIN-1:0] pin_in,
   input logic [NPIN-1:0] pin_out,
   input logic [NPIN-1:0] pin_oe
);
   logic [NPIN-1:0] wmask;
   logic wr, rd, mapped_wr;
   logic [1:0] age;
   assign wmask = req_wdata[NPIN-1:0];
   assign wr = req_valid & req_write;
   assign rd = req_valid & ~req_write;
   assign mapped_wr = (req_addr == AW'(8'h00)) || (req_addr == AW'(8'h10)) ||
                      (req_addr == AW'(8'h20)) || (req_addr == AW'(8'h30));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R1: quiet outputs while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (pin_out == '0 && pin_oe == '0 && !rsp_valid);
      end
   end

   a_r2_level_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && req_addr == AW'(8'h00)) |=>
      (pin_out == ($past(pin_out) | $past(wmask))));

   a_r3_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && req_addr == AW'(8'h10)) |=>
      (pin_out == ($past(pin_out) & ~$past(wmask))));

   a_r4_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && req_addr == AW'(8'h20)) |=>
      (pin_oe == ($past(pin_oe) | $past(wmask))));

   a_r5_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && req_addr == AW'(8'h30)) |=>
      (pin_oe == ($past(pin_oe) & ~$past(wmask))));

   a_r6_pin_read: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(rd && req_addr == AW'(8'h40))) |->
      (rsp_rdata == 32'($past(pin_in, 3))));

   a_r7_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr != AW'(8'h40)) |=> (rsp_rdata == '0));

   a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !mapped_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

   a_r9_read_response: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rsp_valid);

   a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rsp_valid);

   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_setclr_port gsc_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_setclr_port.sv
module sim_gpio_setclr_port;
   localparam int CLK_PERIOD = 10;
   localparam int NPIN = 32;
   localparam int AW   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic rsp_valid;
   logic [31:0] rsp_rdata;
   logic [NPIN-1:0] pin_in, pin_out, pin_oe;
   logic [NPIN-1:0] ext = '0;

   int checks = 0, failures = 0;
   logic [31:0] m_out = '0, m_oe = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // pad model: a driven pin shows its output level, a released one the outside level
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

   gpio_setclr_port #(.NPIN(NPIN), .AW(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic v);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata; v = rsp_valid;
   endtask

   task automatic apply_model(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h00: m_out = m_out | d;
         8'h10: m_out = m_out & ~d;
         8'h20: m_oe  = m_oe | d;
         8'h30: m_oe  = m_oe & ~d;
         default: ;
      endcase
   endtask

   task automatic wr_check(input string req, input logic [7:0] a, input logic [31:0] d);
      do_write(a, d);
      apply_model(a, d);
      check(req, pin_out, m_out);
      check(req, pin_oe, m_oe);
      check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      logic [31:0] d;
      logic v;
      logic [31:0] pat;
      repeat (3) @(negedge clk);
      // R1 during and after reset
      check("R1 out in reset", pin_out, 0);
      check("R1 oe in reset", pin_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out after reset", pin_out, 0);
      check("R1 oe after reset", pin_oe, 0);
      check("R1 rsp_valid", {31'd0, rsp_valid}, 0);

      // R2/R3: walking one on set then clear
      for (int n = 0; n < NPIN; n++) wr_check("R2 walk set", 8'h00, 32'd1 << n);
      for (int n = 0; n < NPIN; n += 2) wr_check("R3 walk clear", 8'h10, 32'd1 << n);
      // R4/R5 walking patterns
      for (int n = 0; n < NPIN; n += 3) wr_check("R4 walk enable", 8'h20, 32'd1 << n);
      for (int n = 0; n < NPIN; n += 6) wr_check("R5 walk release", 8'h30, 32'd1 << n);

      // R2..R5 with arithmetic patterns
      for (int k = 0; k < 24; k++) begin
         pat = 32'h9E37_79B9 * (k + 1);
         pat = pat ^ (pat >> 13);
         wr_check("R2 pattern set", 8'h00, pat);
         wr_check("R3 pattern clear", 8'h10, pat >> 3);
         wr_check("R4 pattern enable", 8'h20, ~pat);
         wr_check("R5 pattern release", 8'h30, pat << 5);
      end
      wr_check("R2 all ones", 8'h00, 32'hFFFF_FFFF);
      wr_check("R4 all ones", 8'h20, 32'hFFFF_FFFF);
      wr_check("R3 zero word keeps", 8'h10, 32'h0);
      wr_check("R5 zero word keeps", 8'h30, 32'h0);

      // R8: every undecoded offset leaves outputs alone
      for (int a = 0; a < 256; a++) begin
         if (a != 8'h00 && a != 8'h10 && a != 8'h20 && a != 8'h30)
            wr_check("R8 unmapped write", 8'(a), 32'h5A5A_A5A5 ^ 32'(a));
      end

      // R7/R9: every offset other than 0x40 reads 0 with one response
      for (int a = 0; a < 256; a++) begin
         if (a != 8'h40) begin
            do_read(8'(a), d, v);
            check("R7 zero read", d, 0);
            check("R9 read rsp_valid", {31'd0, v}, 1);
         end
      end
      @(negedge clk);
      check("R9 rsp_valid drops", {31'd0, rsp_valid}, 0);

      // R6: pad read-back under several drive mixes
      for (int k = 0; k < 16; k++) begin
         ext = 32'hC3A5_0F96 * (k + 7);
         wr_check("R4 mix enable", 8'h20, 32'h1111_1111 << (k % 4));
         wr_check("R5 mix release", 8'h30, 32'h8888_8888 >> (k % 3));
         repeat (3) @(negedge clk);
         do_read(8'h40, d, v);
         check("R6 pin read", d, (m_oe & m_out) | (~m_oe & ext));
         check("R9 pin read valid", {31'd0, v}, 1);
      end

      // R6 timing: change visible to the read accepted at the third edge
      wr_check("R5 release all", 8'h30, 32'hFFFF_FFFF);
      ext = 32'h0;
      repeat (4) @(negedge clk);
      ext = 32'hDEAD_BEEF;
      do_read(8'h40, d, v);
      check("R6 first edge old", d, 32'h0);
      do_read(8'h40, d, v);
      check("R6 second edge old", d, 32'h0);
      do_read(8'h40, d, v);
      check("R6 third edge new", d, 32'hDEAD_BEEF);

      // R9: back-to-back write then read of the pads sees the level only later
      ext = 32'h0;
      repeat (4) @(negedge clk);
      wr_check("R2 drive high", 8'h00, 32'hFFFF_FFFF);
      wr_check("R4 drive on", 8'h20, 32'h0000_00FF);
      repeat (3) @(negedge clk);
      do_read(8'h40, d, v);
      check("R6 driven pins", d, 32'h0000_00FF);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule